// File: doc/BRIEF.md
# Gamma Table Register Loader

The block keeps a table of twelve 10-bit gamma control points. At power-up the table holds a built-in default curve. Software can rewrite any point through a simple indexed write port. A start pulse turns the whole table into a fixed series of fifteen 8-bit register writes for a display panel. These writes leave on a valid/ready stream toward a command serializer.

Each write first splits into its high and low parts. The top two bits of four points go together into one packed register, so three packed writes come first. Twelve low-byte writes follow them. When a load starts, the block takes a snapshot of the table. Points written while the load runs therefore wait for the next load.

The output stream follows the usual back-pressure rules. Once `wr_valid` is high, it stays high and `wr_addr`/`wr_data` stay frozen until the cycle in which `wr_ready` is high. A write counts as transferred only at a clock edge where both signals are high. The sink may hold `wr_ready` low for any number of cycles.

Top module: `gamma_loader`

## Requirements
- R1: After reset the table holds the points 105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023 (index 0 to 11), and a load issued without prior table writes emits exactly those values.
- R2: One load emits exactly 15 writes, in this order: addresses 0x11, 0x12, 0x13, then 0x14 up to 0x1F. Each accepted address is one above the previous one.
- R3: The packed write at 0x11+g carries bits 9:8 of points 4g, 4g+1, 4g+2, 4g+3 in data bits 7:6, 5:4, 3:2 and 1:0 respectively.
- R4: The write at address 0x14+i carries bits 7:0 of point i.
- R5: `wr_valid` rises in the cycle after the edge that samples `load_start`. While `wr_valid` is high and `wr_ready` is low, the next cycle keeps `wr_valid` high with unchanged `wr_addr` and `wr_data`.
- R6: `busy` is high from the cycle after a start until the fifteenth write is accepted. `done` is high for exactly one cycle, the cycle after that acceptance, and in that cycle `busy` and `wr_valid` are low. After reset `busy`, `done` and `wr_valid` are low.
- R7: `load_start` while `busy` is high is ignored: the running sequence neither restarts nor skips, and no extra writes follow it.
- R8: Table writes made while a load runs do not change that load's data; the next load uses them.
- R9: A table write with index 12 to 15 changes no point.
- R10: A table write while idle (`pt_wr_en` high, index `pt_wr_idx`, value `pt_wr_val`) replaces that point for every later load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_wr_en | input | 1 | Table point write strobe |
| pt_wr_idx | input | 4 | Index of the point to write |
| pt_wr_val | input | 10 | New point value |
| load_start | input | 1 | Start a load (sampled while idle only) |
| busy | output | 1 | Load sequence in progress |
| done | output | 1 | One-cycle pulse after the last write is accepted |
| wr_valid | output | 1 | Register write request valid |
| wr_ready | input | 1 | Serializer accepts the request |
| wr_addr | output | 6 | Panel register address |
| wr_data | output | 8 | Panel register data |

## Verification
The bench pushes the fifteen writes it expects into a scoreboard queue. A monitor then checks each accepted write under random back-pressure, so a design that moved its address or data while stalled would fail the compare. A packed register with its bit pairs reversed, or a low byte routed to the wrong address, shows up as a data or address mismatch.

A second start pulse in the middle of a load would make a restarting design emit surplus writes into an empty queue. Table updates made during a load would appear too early in a design that had no snapshot. Writes to indices 12 to 15 would corrupt a point if the index decode were too wide. A `done` that came early, lasted two cycles, or overlapped `busy` would be caught at the pulse itself.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Factory curve, index 0..11
  function automatic logic [15:0] default_point(input int idx);
    logic [15:0] v;
    case (idx)
      0:       v = 16'd105;
      1:       v = 16'd315;
      2:       v = 16'd381;
      3:       v = 16'd431;
      4:       v = 16'd490;
      5:       v = 16'd537;
      6:       v = 16'd579;
      7:       v = 16'd686;
      8:       v = 16'd780;
      9:       v = 16'd837;
      10:      v = 16'd880;
      default: v = 16'd1023;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/gamma_table.sv
module gamma_table #(
  parameter int NPTS  = 12,
  parameter int PT_W  = 10,
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [PT_W-1:0]        wr_val,
  input  logic                   capture,
  output logic [NPTS*PT_W-1:0]   snap_flat
);

  for (genvar i = 0; i < NPTS; i++) begin : g_pt
    localparam logic [PT_W-1:0] DEF = PT_W'(gamma_pkg::default_point(i));
    logic [PT_W-1:0] live_q;
    logic [PT_W-1:0] shadow_q;
    logic            hit;

    assign hit = wr_en && (int'(wr_idx) == i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q   <= DEF;
        shadow_q <= DEF;
      end else begin
        if (hit) live_q <= wr_val;
        if (capture) shadow_q <= live_q;
      end
    end

    assign snap_flat[i*PT_W +: PT_W] = shadow_q;
  end

endmodule

// File: rtl/gamma_seq.sv
module gamma_seq #(
  parameter int NSTEP  = 15,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              accept,
  output logic              busy,
  output logic              done,
  output logic              capture,
  output logic [STEP_W-1:0] step
);
  import gamma_pkg::*;

  localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEP - 1);

  seq_state_e state_q;

  assign busy    = (state_q == SEQ_RUN);
  assign capture = start && (state_q == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      step    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            step    <= '0;
          end
        end
        default: begin
          if (accept) begin
            if (step == LAST) begin
              state_q <= SEQ_IDLE;
              done    <= 1'b1;
              step    <= '0;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/gamma_fmt.sv
module gamma_fmt #(
  parameter int NPTS    = 12,
  parameter int PT_W    = 10,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int GRP     = 4,
  parameter int HI_BASE = 'h11,
  parameter int LO_BASE = 'h14,
  parameter int STEP_W  = 4
) (
  input  logic [NPTS*PT_W-1:0] snap_flat,
  input  logic [STEP_W-1:0]    step,
  output logic [ADDR_W-1:0]    addr,
  output logic [DATA_W-1:0]    data
);

  localparam int HB  = PT_W - DATA_W;
  localparam int NHI = NPTS / GRP;

  logic [PT_W-1:0]     pts     [NPTS];
  logic [NHI*DATA_W-1:0] hi_flat;

  for (genvar i = 0; i < NPTS; i++) begin : g_unpack
    assign pts[i] = snap_flat[i*PT_W +: PT_W];
  end

  // First point of a group lands in the top bit pair
  for (genvar g = 0; g < NHI; g++) begin : g_grp
    logic [DATA_W-1:0] w;
    for (genvar k = 0; k < GRP; k++) begin : g_slot
      assign w[DATA_W-1-k*HB -: HB] = pts[g*GRP+k][PT_W-1 -: HB];
    end
    assign hi_flat[g*DATA_W +: DATA_W] = w;
  end

  always_comb begin
    addr = '0;
    data = '0;
    for (int g = 0; g < NHI; g++) begin
      if (int'(step) == g) begin
        addr = ADDR_W'(HI_BASE + g);
        data = hi_flat[g*DATA_W +: DATA_W];
      end
    end
    for (int i = 0; i < NPTS; i++) begin
      if (int'(step) == NHI + i) begin
        addr = ADDR_W'(LO_BASE + i);
        data = pts[i][DATA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/gamma_loader.sv
module gamma_loader #(
  parameter int NPTS    = 12,
  parameter int PT_W    = 10,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int GRP     = 4,
  parameter int HI_BASE = 'h11,
  parameter int LO_BASE = 'h14,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pt_wr_en,
  input  logic [IDX_W-1:0]  pt_wr_idx,
  input  logic [PT_W-1:0]   pt_wr_val,
  input  logic              load_start,
  output logic              busy,
  output logic              done,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int NHI    = NPTS / GRP;
  localparam int NSTEP  = NHI + NPTS;
  localparam int STEP_W = $clog2(NSTEP);

  logic [NPTS*PT_W-1:0] snap_flat;
  logic                 capture;
  logic [STEP_W-1:0]    step;

  gamma_table #(.NPTS(NPTS), .PT_W(PT_W), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (pt_wr_en),
    .wr_idx    (pt_wr_idx),
    .wr_val    (pt_wr_val),
    .capture   (capture),
    .snap_flat (snap_flat)
  );

  gamma_seq #(.NSTEP(NSTEP), .STEP_W(STEP_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (load_start),
    .accept  (wr_valid && wr_ready),
    .busy    (busy),
    .done    (done),
    .capture (capture),
    .step    (step)
  );

  gamma_fmt #(
    .NPTS(NPTS), .PT_W(PT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GRP(GRP),
    .HI_BASE(HI_BASE), .LO_BASE(LO_BASE), .STEP_W(STEP_W)
  ) u_fmt (
    .snap_flat (snap_flat),
    .step      (step),
    .addr      (wr_addr),
    .data      (wr_data)
  );

  assign wr_valid = busy;

endmodule

// File: rtl/gamma_loader_chk.sv
module gamma_loader_chk #(
  parameter int NPTS    = 12,
  parameter int PT_W    = 10,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int GRP     = 4,
  parameter int HI_BASE = 'h11,
  parameter int LO_BASE = 'h14,
  parameter int IDX_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pt_wr_en,
  input logic [IDX_W-1:0]  pt_wr_idx,
  input logic [PT_W-1:0]   pt_wr_val,
  input logic              load_start,
  input logic              busy,
  input logic              done,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);

  localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(LO_BASE + NPTS - 1);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> (wr_addr == FIRST));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr != LAST) |=> (wr_addr == $past(wr_addr) + 1'b1));

  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr == LAST) |=> (done && !busy && !wr_valid));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load_start && !wr_ready) |=> $stable(wr_addr));

endmodule

bind gamma_loader gamma_loader_chk #(
  .NPTS(NPTS), .PT_W(PT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GRP(GRP),
  .HI_BASE(HI_BASE), .LO_BASE(LO_BASE), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/test_gamma_loader.sv
module test_gamma_loader;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pt_wr_en = 1'b0;
  logic [3:0] pt_wr_idx = '0;
  logic [9:0] pt_wr_val = '0;
  logic       load_start = 1'b0;
  logic       busy, done, wr_valid;
  logic       wr_ready;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  bit finished = 1'b0;
  bit bp       = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  logic [9:0]  exp_tbl [12];
  logic [13:0] exp_q [$];

  always #10 clk = ~clk;

  gamma_loader i_gamma_loader (
    .clk(clk), .rst_n(rst_n), .pt_wr_en(pt_wr_en), .pt_wr_idx(pt_wr_idx),
    .pt_wr_val(pt_wr_val), .load_start(load_start), .busy(busy), .done(done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // ready pattern, changed just after each edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready = bp ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  bit          hold_pend = 1'b0;
  logic [13:0] hold_item;
  bit          prev_hs = 1'b0;
  bit          prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        check(wr_valid && {wr_addr, wr_data} == hold_item, "R5 stall hold",
              {wr_valid, wr_addr, wr_data}, {1'b1, hold_item});
      hold_pend = wr_valid && !wr_ready;
      hold_item = {wr_addr, wr_data};
      if (done) begin
        check(!busy && !wr_valid && prev_hs && exp_q.size() == 0, "R6 done timing",
              {busy, wr_valid, prev_hs}, 3'b001);
        check(!prev_done, "R6 done one cycle", 1, 0);
        done_cnt++;
      end
      prev_done = done;
      prev_hs = 1'b0;
      if (wr_valid && wr_ready) begin
        prev_hs = 1'b1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected write", {wr_addr, wr_data}, 0);
        end else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          if (e[13:8] < 6'h14)
            check({wr_addr, wr_data} == e, "R2 R3 packed write", {wr_addr, wr_data}, e);
          else
            check({wr_addr, wr_data} == e, "R2 R4 low-byte write", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  function automatic logic [7:0] hi_pack(input int g);
    return {exp_tbl[4*g][9:8], exp_tbl[4*g+1][9:8], exp_tbl[4*g+2][9:8], exp_tbl[4*g+3][9:8]};
  endfunction

  task automatic push_load();
    for (int g = 0; g < 3; g++) exp_q.push_back({6'(8'h11 + g), hi_pack(g)});
    for (int i = 0; i < 12; i++) exp_q.push_back({6'(8'h14 + i), exp_tbl[i][7:0]});
  endtask

  task automatic pulse_start();
    @(posedge clk); #2 load_start = 1'b1;
    @(posedge clk); #2 load_start = 1'b0;
  endtask

  task automatic write_pt(input int idx, input int val);
    @(posedge clk); #2;
    pt_wr_en = 1'b1; pt_wr_idx = 4'(idx); pt_wr_val = 10'(val);
    @(posedge clk); #2 pt_wr_en = 1'b0;
    if (idx < 12) exp_tbl[idx] = 10'(val);
  endtask

  task automatic wait_done();
    int d0;
    d0 = done_cnt;
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic run_load();
    push_load();
    pulse_start();
    @(negedge clk);
    check(busy && wr_valid, "R5 R6 valid after start", {busy, wr_valid}, 2'b11);
    wait_done();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int defs [12] = '{105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023};
    for (int i = 0; i < 12; i++) exp_tbl[i] = 10'(defs[i]);
    wr_ready = 1'b1;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !wr_valid, "R6 reset state", {busy, done, wr_valid}, 0);

    // R1: default curve, no back-pressure
    run_load();

    // R10: idle updates, random back-pressure (R5)
    write_pt(0, 10'h3FF);
    write_pt(5, 10'h155);
    write_pt(11, 10'h000);
    write_pt(6, 10'h2AA);
    bp = 1'b1;
    run_load();

    // R7, R8: updates and second start during a load
    push_load();
    pulse_start();
    write_pt(3, 10'h1C3);
    load_start = 1'b1; @(posedge clk); #2 load_start = 1'b0;
    write_pt(8, 10'h0F0);
    wait_done();
    repeat (10) @(negedge clk);
    check(!busy && !wr_valid && exp_q.size() == 0, "R7 no restart", {busy, wr_valid}, 0);
    run_load();  // R8: new values appear now

    // R9: out-of-range indices
    write_pt(12, 10'h111);
    write_pt(15, 10'h222);
    bp = 1'b0;
    run_load();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
    finish_run();
  end

endmodule